// File: doc/BRIEF.md
# Load Dependence Predictor with Confidence Gate

This block sits beside the issue stage of an out-of-order core. Before a load is issued, the issue stage asks whether that load may go ahead of an older store whose address is not yet known. The block keeps a direct-mapped table. The table is indexed by the load's PC and learns from conflicts seen in the past. Each entry records the load that once read stale data, a short fingerprint of the store it collided with, and a small saturating confidence counter that measures trust in the load's independence. When that confidence is at or above a threshold supplied at run time, the load speculates. Otherwise it waits.

The load-store queue trains the table in two ways. A violation report names a load and a store that really aliased. This report allocates or overwrites the entry and clears its confidence. A correct-speculation report names a load that bypassed safely, and it raises that load's confidence by one. A lower threshold makes the core more aggressive. The decision for a query appears one cycle after the query.

Top module: `mdp_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dec_valid_o` and `dec_spec_o` are 0. Reset leaves every table entry empty, so every load misses until it is trained.
- R2: `dec_valid_o` equals `q_valid_i` of the previous cycle. `dec_spec_o` carries the decision for that query, where 1 means speculate and 0 means stall. `dec_spec_o` is 0 when the previous cycle had no query.
- R3: A query with `q_unres_i` = 0 (no older store is unresolved) is always allowed to speculate.
- R4: A query whose load misses the table (index `pc[5:0]`, tag `pc[15:6]`, entry empty or tag different) speculates only when `thresh_i` is 0.
- R5: A violation report writes the entry at the load's index. It marks the entry present, sets the load tag, stores the store fingerprint, and sets the confidence to 0. The store fingerprint is the XOR of the PC's 8-bit chunks.
- R6: A correct-speculation report that hits the table raises the confidence by 1 and saturates at 7. A report that misses leaves the table unchanged.
- R7: When the load hits and the store fingerprint matches, the load speculates exactly when confidence >= `thresh_i`.
- R8: When the load hits but the queried store fingerprint differs from the recorded one, the load is treated as independent and speculates.
- R9: A query in the same cycle as an update to the same index is decided on the updated entry.
- R10: If a violation and a correct-speculation report name the same index in one cycle, the violation wins and the confidence becomes 0.
- R11: Two loads that share an index but have different tags displace each other. A violation by the second load replaces the first load's entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_i | input | 3 | Confidence needed to speculate |
| q_valid_i | input | 1 | Prediction query present |
| q_load_pc_i | input | 16 | PC of the querying load |
| q_store_pc_i | input | 16 | PC of the oldest unresolved older store |
| q_unres_i | input | 1 | An older store still has an unknown address |
| vio_valid_i | input | 1 | Aliasing violation report |
| vio_load_pc_i | input | 16 | PC of the load that read stale data |
| vio_store_pc_i | input | 16 | PC of the store it collided with |
| ok_valid_i | input | 1 | Correct-speculation report |
| ok_load_pc_i | input | 16 | PC of the load that bypassed safely |
| dec_valid_o | output | 1 | Registered decision present |
| dec_spec_o | output | 1 | 1 speculate, 0 stall |

## Verification
The assertions assume that every input is a known value after reset. They also assume that `q_store_pc_i` is meaningful only when `q_unres_i` is high. The same-cycle bypass property assumes that both reports may be raised together in any cycle. The stimulus keeps every input driven at all times, including the PCs when their valid flags are low. It draws load PCs from a few tags over a few indices, so hits, tag aliasing and same-index collisions happen often. It also mixes in all eight threshold values.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  // True when the stored confidence clears the configured bar.
  function automatic logic gate_open(input int unsigned conf, input int unsigned bar);
    return conf >= bar;
  endfunction
endpackage

// File: rtl/mdp_table.sv
module mdp_table #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 10,
  parameter int STAG_W = 8,
  parameter int CONF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vio_en_i,
  input  logic [IDX_W-1:0]  vio_idx_i,
  input  logic [TAG_W-1:0]  vio_tag_i,
  input  logic [STAG_W-1:0] vio_stag_i,
  input  logic              bump_en_i,
  input  logic [IDX_W-1:0]  bump_idx_i,
  input  logic [TAG_W-1:0]  bump_tag_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [STAG_W-1:0] rd_stag_o,
  output logic [CONF_W-1:0] rd_conf_o,
  output logic              bump_go_o
);
  localparam int ENTRIES = 1 << IDX_W;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic [STAG_W-1:0] stag;
    logic [CONF_W-1:0] conf;
  } ent_t;

  function automatic logic [CONF_W-1:0] conf_bump(input logic [CONF_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  ent_t tbl [ENTRIES];
  ent_t bump_ent;
  ent_t fresh;
  ent_t cur;
  logic bump_hit;
  logic same_slot;

  always_comb begin
    bump_ent  = tbl[bump_idx_i];
    bump_hit  = bump_en_i && bump_ent.vld && (bump_ent.tag == bump_tag_i);
    same_slot = vio_en_i && (vio_idx_i == bump_idx_i);
    bump_go_o = bump_hit && !same_slot;
    fresh     = '{vld: 1'b1, tag: vio_tag_i, stag: vio_stag_i, conf: '0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (vio_en_i && (vio_idx_i == IDX_W'(e)))
          tbl[e] <= fresh;
        else if (bump_go_o && (bump_idx_i == IDX_W'(e)))
          tbl[e].conf <= conf_bump(tbl[e].conf);
      end
    end
  end

  // Read port with update forwarding for the same index.
  always_comb begin
    cur = tbl[rd_idx_i];
    if (vio_en_i && (vio_idx_i == rd_idx_i))
      cur = fresh;
    else if (bump_go_o && (bump_idx_i == rd_idx_i))
      cur.conf = conf_bump(cur.conf);
    rd_vld_o  = cur.vld;
    rd_tag_o  = cur.tag;
    rd_stag_o = cur.stag;
    rd_conf_o = cur.conf;
  end
endmodule

// File: rtl/mdp_decide.sv
module mdp_decide #(
  parameter int TAG_W  = 10,
  parameter int STAG_W = 8,
  parameter int CONF_W = 3
) (
  input  logic              q_unres_i,
  input  logic              ent_vld_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [TAG_W-1:0]  q_tag_i,
  input  logic [STAG_W-1:0] ent_stag_i,
  input  logic [STAG_W-1:0] q_stag_i,
  input  logic [CONF_W-1:0] ent_conf_i,
  input  logic [CONF_W-1:0] thresh_i,
  output logic              hit_o,
  output logic              dep_o,
  output logic              spec_o
);
  always_comb begin
    hit_o = ent_vld_i && (ent_tag_i == q_tag_i);
    dep_o = hit_o && (ent_stag_i == q_stag_i);
    if (!q_unres_i)      spec_o = 1'b1;
    else if (!hit_o)     spec_o = (thresh_i == '0);
    else if (!dep_o)     spec_o = 1'b1;
    else                 spec_o = mdp_pkg::gate_open(32'(ent_conf_i), 32'(thresh_i));
  end
endmodule

// File: rtl/mdp_gate.sv
module mdp_gate #(
  parameter int PC_W   = 16,
  parameter int IDX_W  = 6,
  parameter int STAG_W = 8,
  parameter int CONF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CONF_W-1:0] thresh_i,
  input  logic              q_valid_i,
  input  logic [PC_W-1:0]   q_load_pc_i,
  input  logic [PC_W-1:0]   q_store_pc_i,
  input  logic              q_unres_i,
  input  logic              vio_valid_i,
  input  logic [PC_W-1:0]   vio_load_pc_i,
  input  logic [PC_W-1:0]   vio_store_pc_i,
  input  logic              ok_valid_i,
  input  logic [PC_W-1:0]   ok_load_pc_i,
  output logic              dec_valid_o,
  output logic              dec_spec_o
);
  localparam int TAG_W = PC_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:IDX_W];
  endfunction

  // Fold a store PC into STAG_W bits by XOR of its chunks.
  function automatic logic [STAG_W-1:0] stag_of(input logic [PC_W-1:0] pc);
    logic [STAG_W-1:0] h;
    h = '0;
    for (int i = 0; i < PC_W; i++) h[i % STAG_W] = h[i % STAG_W] ^ pc[i];
    return h;
  endfunction

  // Named internal events, observed by the bound checker.
  logic              rd_vld;
  logic [TAG_W-1:0]  rd_tag;
  logic [STAG_W-1:0] rd_stag;
  logic [CONF_W-1:0] rd_conf;
  logic              bump_go;
  logic              rd_hit;
  logic              rd_dep;
  logic              spec_now;

  mdp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .STAG_W(STAG_W), .CONF_W(CONF_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .vio_en_i   (vio_valid_i),
    .vio_idx_i  (idx_of(vio_load_pc_i)),
    .vio_tag_i  (tag_of(vio_load_pc_i)),
    .vio_stag_i (stag_of(vio_store_pc_i)),
    .bump_en_i  (ok_valid_i),
    .bump_idx_i (idx_of(ok_load_pc_i)),
    .bump_tag_i (tag_of(ok_load_pc_i)),
    .rd_idx_i   (idx_of(q_load_pc_i)),
    .rd_vld_o   (rd_vld),
    .rd_tag_o   (rd_tag),
    .rd_stag_o  (rd_stag),
    .rd_conf_o  (rd_conf),
    .bump_go_o  (bump_go)
  );

  mdp_decide #(.TAG_W(TAG_W), .STAG_W(STAG_W), .CONF_W(CONF_W)) u_decide (
    .q_unres_i  (q_unres_i),
    .ent_vld_i  (rd_vld),
    .ent_tag_i  (rd_tag),
    .q_tag_i    (tag_of(q_load_pc_i)),
    .ent_stag_i (rd_stag),
    .q_stag_i   (stag_of(q_store_pc_i)),
    .ent_conf_i (rd_conf),
    .thresh_i   (thresh_i),
    .hit_o      (rd_hit),
    .dep_o      (rd_dep),
    .spec_o     (spec_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_spec_o  <= 1'b0;
    end else begin
      dec_valid_o <= q_valid_i;
      dec_spec_o  <= q_valid_i && spec_now;
    end
  end
endmodule

// File: rtl/mdp_gate_chk.sv
module mdp_gate_chk #(
  parameter int PC_W   = 16,
  parameter int CONF_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CONF_W-1:0] thresh_i,
  input logic              q_valid_i,
  input logic [PC_W-1:0]   q_load_pc_i,
  input logic [PC_W-1:0]   q_store_pc_i,
  input logic              q_unres_i,
  input logic              vio_valid_i,
  input logic [PC_W-1:0]   vio_load_pc_i,
  input logic [PC_W-1:0]   vio_store_pc_i,
  input logic              rd_hit,
  input logic              dec_valid_o,
  input logic              dec_spec_o
);
  // R2: the decision strobe trails the query strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid_i |=> dec_valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid_i |=> (!dec_valid_o && !dec_spec_o));
  // R3: nothing unresolved ahead means go
  a_r3_resolved_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && !q_unres_i) |=> dec_spec_o);
  // R4: a table miss stalls under a nonzero bar
  a_r4_miss_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && q_unres_i && !rd_hit && (thresh_i != '0)) |=> !dec_spec_o);
  // R7: a zero bar never stalls
  a_r7_zero_bar_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && (thresh_i == '0)) |=> dec_spec_o);
  // R9: a violation seen in the same cycle as its own query forces a stall
  a_r9_viol_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid_i && q_unres_i && vio_valid_i && (thresh_i != '0) &&
     (q_load_pc_i == vio_load_pc_i) && (q_store_pc_i == vio_store_pc_i)) |=> !dec_spec_o);
endmodule

bind mdp_gate mdp_gate_chk #(.PC_W(PC_W), .CONF_W(CONF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .thresh_i       (thresh_i),
  .q_valid_i      (q_valid_i),
  .q_load_pc_i    (q_load_pc_i),
  .q_store_pc_i   (q_store_pc_i),
  .q_unres_i      (q_unres_i),
  .vio_valid_i    (vio_valid_i),
  .vio_load_pc_i  (vio_load_pc_i),
  .vio_store_pc_i (vio_store_pc_i),
  .rd_hit         (rd_hit),
  .dec_valid_o    (dec_valid_o),
  .dec_spec_o     (dec_spec_o)
);

// File: tb/mdp_gate_bench.sv
module mdp_gate_bench;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  thr = '0;
  logic        qv = 0, qu = 0, vv = 0, ov = 0;
  logic [15:0] qpc = '0, qspc = '0, vlpc = '0, vspc = '0, opc = '0;
  logic        dec_valid, dec_spec;

  int checks = 0;
  int fails  = 0;

  // Reference table
  bit       m_vld  [64];
  bit [9:0] m_tag  [64];
  bit [7:0] m_stag [64];
  int       m_conf [64];

  always #5ns clk = ~clk;

  mdp_gate u_mdp_gate (
    .clk(clk), .rst_n(rst_n), .thresh_i(thr),
    .q_valid_i(qv), .q_load_pc_i(qpc), .q_store_pc_i(qspc), .q_unres_i(qu),
    .vio_valid_i(vv), .vio_load_pc_i(vlpc), .vio_store_pc_i(vspc),
    .ok_valid_i(ov), .ok_load_pc_i(opc),
    .dec_valid_o(dec_valid), .dec_spec_o(dec_spec)
  );

  function automatic bit [7:0] fp(input bit [15:0] pc);
    return pc[15:8] ^ pc[7:0];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, update reference, predict, sample after the edge.
  task automatic tick(input string req);
    bit exp_spec;
    int i;
    bit hit;
    string why;
    @(negedge clk);
    if (vv) begin
      i = vlpc % 64;
      m_vld[i] = 1; m_tag[i] = vlpc[15:6]; m_stag[i] = fp(vspc); m_conf[i] = 0;
    end
    if (ov) begin
      i = opc % 64;
      if (m_vld[i] && m_tag[i] == opc[15:6] && !(vv && (vlpc % 64) == i))
        m_conf[i] = (m_conf[i] == 7) ? 7 : m_conf[i] + 1;
    end
    i = qpc % 64;
    hit = m_vld[i] && (m_tag[i] == qpc[15:6]);
    if (!qu)                        begin exp_spec = 1;                      why = "R3"; end
    else if (!hit)                  begin exp_spec = (thr == 0);             why = "R4"; end
    else if (m_stag[i] != fp(qspc)) begin exp_spec = 1;                      why = "R8"; end
    else                            begin exp_spec = (m_conf[i] >= int'(thr)); why = "R7"; end
    if (!qv) begin exp_spec = 0; why = "R2"; end
    @(posedge clk);
    #1ns;
    check("R2", dec_valid, qv);
    check((req == "") ? why : req, dec_spec, exp_spec);
  endtask

  task automatic idle();
    qv = 0; vv = 0; ov = 0;
  endtask

  task automatic ask(input bit [15:0] l, input bit [15:0] s, input bit [2:0] t, input string req);
    idle(); qv = 1; qu = 1; qpc = l; qspc = s; thr = t;
    tick(req);
  endtask

  task automatic report_viol(input bit [15:0] l, input bit [15:0] s);
    idle(); vv = 1; vlpc = l; vspc = s;
    tick("R5");
  endtask

  task automatic report_ok(input bit [15:0] l, input string req);
    idle(); ov = 1; opc = l;
    tick(req);
  endtask

  localparam bit [15:0] LA = 16'h0045, LB = 16'h0085, LC = 16'h00C7;
  localparam bit [15:0] SA = 16'h0011, SB = 16'h0022, SC = 16'h0300;

  initial begin
    for (int k = 0; k < 64; k++) begin m_vld[k] = 0; m_tag[k] = 0; m_stag[k] = 0; m_conf[k] = 0; end
    repeat (3) @(posedge clk);
    #1ns;
    check("R1", dec_valid, 1'b0);
    check("R1", dec_spec, 1'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1ns;
    check("R1", dec_valid, 1'b0);
    check("R1", dec_spec, 1'b0);

    ask(LA, SA, 3'd1, "R1");            // empty table: stall
    ask(LA, SA, 3'd0, "R4");            // miss with zero bar: go
    idle(); qv = 1; qu = 0; qpc = LA; thr = 3'd7; tick("R3");
    report_viol(LA, SA);
    ask(LA, SA, 3'd1, "R5");            // trained conflict: stall
    // R9: violation and query in one cycle
    idle(); vv = 1; vlpc = LC; vspc = SB; qv = 1; qu = 1; qpc = LC; qspc = SB; thr = 3'd1;
    tick("R9");
    // R9: bump and query in one cycle sees conf 1
    idle(); ov = 1; opc = LC; qv = 1; qu = 1; qpc = LC; qspc = SB; thr = 3'd1;
    tick("R9");
    for (int k = 0; k < 3; k++) report_ok(LA, "R6");
    ask(LA, SA, 3'd3, "R6");
    ask(LA, SA, 3'd4, "R6");
    for (int k = 0; k < 10; k++) report_ok(LA, "R6");
    ask(LA, SA, 3'd7, "R6");            // saturated at 7, no wrap
    report_ok(16'h0009, "R6");          // miss: table unchanged
    ask(16'h0009, SA, 3'd1, "R6");
    report_viol(LA, SA);
    ask(LA, SB, 3'd7, "R8");            // other store: independent
    ask(LA, SC, 3'd7, "R8");
    // R10: both reports on one index
    idle(); vv = 1; vlpc = LA; vspc = SA; ov = 1; opc = LA; tick("R10");
    ask(LA, SA, 3'd1, "R10");
    ask(LB, SA, 3'd1, "R11");           // same index, other tag: miss
    report_viol(LB, SA);
    report_ok(LA, "R11");               // old load now misses
    report_ok(LB, "R11");
    ask(LB, SA, 3'd1, "R11");
    ask(LA, SA, 3'd1, "R11");

    // Constrained random phase
    void'($urandom(32'd7321));
    for (int n = 0; n < 4000; n++) begin
      bit [15:0] lpcs [4];
      bit [15:0] spcs [3];
      lpcs[0] = LA; lpcs[1] = LB; lpcs[2] = LC; lpcs[3] = 16'h0147;
      spcs[0] = SA; spcs[1] = SB; spcs[2] = SC;
      qv   = ($urandom % 4) != 0;
      qu   = ($urandom % 5) != 0;
      qpc  = lpcs[$urandom % 4];
      qspc = spcs[$urandom % 3];
      vv   = ($urandom % 9) == 0;
      vlpc = lpcs[$urandom % 4];
      vspc = spcs[$urandom % 3];
      ov   = ($urandom % 3) == 0;
      opc  = lpcs[$urandom % 4];
      thr  = 3'($urandom % 8);
      tick("");
    end

    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule